// File: doc/BRIEF.md
# Fractional-Increment Constant-Rate Counter

This block is a free-running master count that must tick at one fixed nominal rate (6.144 MHz in the intended system) while the clock feeding it changes frequency with power mode. It does this with a fractional incrementer. On every input clock a programmable step is added into an accumulator. Whenever the accumulator reaches a programmable modulus, the modulus is taken back out and the count advances by one. The long-run count rate is therefore the input rate times step divided by modulus.

Software retunes the step/modulus pair whenever the input clock changes. Typical pairs are 4/25 at 38.4 MHz, 8/25 at 19.2 MHz, 64/125 at 12 MHz, 192/625 at 20 MHz, 256/1125 at 27 MHz, 384/1625 at 26 MHz and 768/1625 at 13 MHz. A pair of 75/244 serves when the slow reference is derived as the input clock divided by 610. Both fields are 12 bits wide and sit at the bottom of 32-bit registers. The count is `2*HALF_W` bits wide (64 by default) and is read as two halves. Reading the low half freezes the high half in a shadow, so a low-then-high read pair is coherent.

Top module: `frac_rate_counter`

## Requirements
- R1: After synchronous reset the count and the accumulator are zero, the step field holds `STEP_RST` (default 4) and the modulus field holds `MOD_RST` (default 25).
- R2: With a nonzero modulus larger than the step, the count advances by exactly floor(N*step/modulus) over the N clocks that follow the last ratio write.
- R3: The count advances by at most one per clock, and the accumulator stays below a nonzero modulus at all times.
- R4: When the step is greater than or equal to a nonzero modulus, the count advances on every clock and the accumulator stays at zero.
- R5: When the modulus is zero, the count holds its value.
- R6: A write to the step or the modulus register clears the accumulator, and the count does not advance on that clock.
- R7: A ratio write takes only bits 11:0 of `wr_data`. Bits 31:12 are ignored and read back as zero.
- R8: A read of the low count half (address 0x00) returns the live low half and copies the live high half into a shadow. A read of the high half (address 0x04) returns the shadow, not the live value.
- R9: The register map is: count low 0x00, count high 0x04, step 0x08, modulus 0x0C. `rd_data` is valid one clock after `rd_en`. Reads of any other address return zero. Writes to the count addresses have no effect.
- R10: The count wraps modulo 2^(2*HALF_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Varying-frequency input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register read byte address |
| rd_data | output | 32 | Registered read data, valid one clock after rd_en |

## Verification
A wrong accumulator value leaves every individual tick plausible. It shows at the ports only as a count difference that drifts from floor(N*step/modulus), so each ratio is run long enough for an exact multiple of the modulus to elapse, and one run uses a non-integer product. A stale accumulator carried across a ratio write shifts that difference by one within the first modulus period. A shadow that tracks the live high half shows as soon as the high half is read long after the low half.

// File: rtl/frac_ctr_pkg.sv
package frac_ctr_pkg;
  localparam int ADDR_W = 5;
  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 5'h00,
    A_CNT_HI = 5'h04,
    A_STEP   = 5'h08,
    A_MOD    = 5'h0C
  } reg_addr_e;
endpackage

// File: rtl/frac_ratio_regs.sv
module frac_ratio_regs
  import frac_ctr_pkg::*;
#(
  parameter int FRAC_W   = 12,
  parameter int STEP_RST = 4,
  parameter int MOD_RST  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [FRAC_W-1:0] wr_field,
  output logic [FRAC_W-1:0] step_q,
  output logic [FRAC_W-1:0] mod_q,
  output logic              ratio_wr
);
  logic hit_step, hit_mod;

  assign hit_step = wr_en && (wr_addr == A_STEP);
  assign hit_mod  = wr_en && (wr_addr == A_MOD);
  assign ratio_wr = hit_step || hit_mod;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= FRAC_W'(STEP_RST);
      mod_q  <= FRAC_W'(MOD_RST);
    end else begin
      if (hit_step) step_q <= wr_field;
      if (hit_mod)  mod_q  <= wr_field;
    end
  end

  // R7: field takes the written low bits
  a_r7_step_takes_field: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_STEP) |=> step_q == $past(wr_field));
  a_r7_mod_takes_field: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_MOD) |=> mod_q == $past(wr_field));
endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W-1:0] step,
  input  logic [FRAC_W-1:0] modulus,
  input  logic              clear,
  output logic              tick
);
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, step};

  always_comb begin
    acc_d = acc_q;
    tick  = 1'b0;
    if (clear) begin
      acc_d = '0;
    end else if (modulus == '0) begin
      acc_d = acc_q;
    end else if (step >= modulus) begin
      acc_d = '0;
      tick  = 1'b1;
    end else if (sum >= {1'b0, modulus}) begin
      acc_d = FRAC_W'(sum - {1'b0, modulus});
      tick  = 1'b1;
    end else begin
      acc_d = sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  // R3: remainder kept below a nonzero modulus
  a_r3_acc_below_mod: assert property (@(posedge clk) disable iff (rst)
    (modulus != '0) |-> acc_q < modulus);
  // R6: ratio update restarts the remainder
  a_r6_clear_zeroes_acc: assert property (@(posedge clk) disable iff (rst)
    clear |=> acc_q == '0);
endmodule

// File: rtl/frac_count_rd.sv
module frac_count_rd
  import frac_ctr_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int DATA_W = 32,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [FRAC_W-1:0] step,
  input  logic [FRAC_W-1:0] modulus,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0]  count_q;
  logic [HALF_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      shadow_q <= '0;
      rd_data  <= '0;
    end else begin
      count_q <= count_q + CNT_W'(tick);
      if (rd_en) begin
        case (rd_addr)
          A_CNT_LO: begin
            rd_data  <= DATA_W'(count_q[HALF_W-1:0]);
            shadow_q <= count_q[CNT_W-1:HALF_W];
          end
          A_CNT_HI: rd_data <= DATA_W'(shadow_q);
          A_STEP:   rd_data <= DATA_W'(step);
          A_MOD:    rd_data <= DATA_W'(modulus);
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  // R1: count leaves reset at zero
  a_r1_count_zero_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> count_q == '0);
  // R3: at most one step per clock
  a_r3_step_le_one: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));
  // R5: zero modulus freezes the count
  a_r5_zero_mod_holds: assert property (@(posedge clk) disable iff (rst)
    (modulus == '0) |=> $stable(count_q));
  // R8: shadow moves only on a low-half read
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && rd_addr == A_CNT_LO) |=> $stable(shadow_q));
endmodule

// File: rtl/frac_rate_counter.sv
module frac_rate_counter
  import frac_ctr_pkg::*;
#(
  parameter int HALF_W   = 32,
  parameter int DATA_W   = 32,
  parameter int FRAC_W   = 12,
  parameter int STEP_RST = 4,
  parameter int MOD_RST  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [4:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [4:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [FRAC_W-1:0] step_q, mod_q;
  logic              ratio_wr, tick;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:FRAC_W];

  frac_ratio_regs #(
    .FRAC_W(FRAC_W), .STEP_RST(STEP_RST), .MOD_RST(MOD_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_field(wr_data[FRAC_W-1:0]), .step_q(step_q), .mod_q(mod_q),
    .ratio_wr(ratio_wr)
  );

  frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst(rst), .step(step_q), .modulus(mod_q),
    .clear(ratio_wr), .tick(tick)
  );

  frac_count_rd #(
    .HALF_W(HALF_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W)
  ) u_count (
    .clk(clk), .rst(rst), .tick(tick), .rd_en(rd_en), .rd_addr(rd_addr),
    .step(step_q), .modulus(mod_q), .rd_data(rd_data)
  );
endmodule

// File: tb/frac_rate_counter_tb.sv
module frac_rate_counter_tb;
  localparam logic [4:0] A_LO = 5'h00, A_HI = 5'h04, A_ST = 5'h08, A_MD = 5'h0C;
  localparam int NV = 9;
  // {step, modulus, wait, expected count difference}
  localparam logic [47:0] VEC [NV] = '{
    {12'd64,  12'd125,  12'd248,  12'd128},
    {12'd8,   12'd25,   12'd98,   12'd32},
    {12'd4,   12'd25,   12'd123,  12'd20},
    {12'd192, 12'd625,  12'd623,  12'd192},
    {12'd768, 12'd1625, 12'd1623, 12'd768},
    {12'd256, 12'd1125, 12'd1123, 12'd256},
    {12'd384, 12'd1625, 12'd1623, 12'd384},
    {12'd75,  12'd244,  12'd242,  12'd75},
    {12'd64,  12'd125,  12'd8,    12'd5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  frac_rate_counter #(.HALF_W(8)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data; rd_en = 1'b0;
  endtask

  task automatic read_count(output logic [15:0] v);
    logic [31:0] lo, hi;
    read_reg(A_LO, lo); read_reg(A_HI, hi);
    v = {hi[7:0], lo[7:0]};
  endtask

  task automatic measure(input logic [31:0] s, input logic [31:0] m, input int w,
                         output logic [15:0] diff);
    logic [15:0] v0, v1;
    write_reg(A_ST, s); write_reg(A_MD, m);
    read_count(v0);
    repeat (w) @(negedge clk);
    read_count(v1);
    diff = v1 - v0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] df, va, vb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    read_reg(A_LO, d); check("R1 count low", d, 0);
    read_reg(A_HI, d); check("R1 count high", d, 0);
    read_reg(A_ST, d); check("R1 step reset", d, 4);
    read_reg(A_MD, d); check("R1 modulus reset", d, 25);

    // R2 R3 R6: table of ratios, each restarted by a ratio write
    for (int i = 0; i < NV; i++) begin
      measure(32'(VEC[i][47:36]), 32'(VEC[i][35:24]), int'(VEC[i][23:12]), df);
      check("R2 R3 R6 ratio run", 32'(df), 32'(VEC[i][11:0]));
    end

    // R7: upper bits ignored
    measure(32'hFFFFF040, 32'hABCDE07D, 248, df);
    check("R7 rate from low field", 32'(df), 128);
    read_reg(A_ST, d); check("R7 step readback", d, 32'h40);
    read_reg(A_MD, d); check("R7 modulus readback", d, 32'h7D);

    // R4: step >= modulus advances every clock
    measure(30, 25, 10, df);
    check("R4 every clock", 32'(df), 12);

    // R8: shadow holds across a long gap
    read_count(va);
    repeat (600) @(negedge clk);
    read_reg(A_HI, d);
    check("R8 shadow high", d, 32'(va[15:8]));
    read_count(vb);
    check("R8 live high moved", 32'(vb[15:8] != va[15:8]), 1);

    // R10: wrap after 2^16 increments
    measure(30, 25, 65534, df);
    check("R10 wrap", 32'(df), 0);

    // R5: zero modulus holds the count
    measure(1, 0, 50, df);
    check("R5 hold", 32'(df), 0);

    // R9: count writes ignored, unmapped reads zero
    read_count(va);
    write_reg(A_LO, 32'hFF); write_reg(A_HI, 32'hFF);
    read_count(vb);
    check("R9 count write ignored", 32'(vb), 32'(va));
    read_reg(5'h10, d); check("R9 unmapped read", d, 0);
    read_reg(5'h1C, d); check("R9 unmapped read high", d, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule